// File: doc/BRIEF.md
# Dual Timer/Counter with External Interrupt Flags

The block holds two identical 16-bit timer/counter channels and two external interrupt detectors. All of them are controlled through six byte-wide registers on a simple register bus. Each channel either advances on every clock as a timer, or advances once per falling edge of its event line as a counter. A channel can also be held back by an external gate level, and it sets an overflow flag when it wraps. Each channel has three counting modes: a 13-bit count, a 16-bit count, and an 8-bit count with auto-reload.

The two interrupt inputs are active low. For each one, a flag is set either on a falling edge or for as long as the input stays low, as chosen by a type bit. Overflow flags and interrupt flags can be cleared by software, and they also clear on an acknowledge pulse from the surrounding interrupt logic. Some pairings of the two channel modes are not allowed, and the block reports them on `cfg_err`.

Register map (byte address on `bus_addr`):

- 0: mode register
- 1: control register
- 2: channel 0 low count byte
- 3: channel 0 high count byte
- 4: channel 1 low count byte
- 5: channel 1 high count byte

Addresses 6 and 7 read as zero. Reads are combinational. A write takes effect at the clock edge on which `bus_we` is high.

Top module: `dual_tc`

## Requirements
- R1: Mode register: channel 0 uses bits [3:0] and channel 1 uses bits [7:4]. In each nibble, bit 3 is gate-enable, bit 2 is event-count select, and bits [1:0] are the mode. `cfg_err` is 1 whenever either mode field is 3, or channel 0 is in mode 2 while channel 1 is in mode 0 or 1.
- R2: A running channel with event-count select 0 and gate-enable 0 advances by one on every clock.
- R3: While a channel's run bit is 0, its count bytes keep their value unless written.
- R4: With gate-enable set, a running channel advances only in cycles where its gate input, after a two-flop synchronizer, is high.
- R5: With event-count select set, the channel advances once per falling edge of its event input. The edge is detected after a two-flop synchronizer, so the count changes on the third rising clock edge after the input falls.
- R6: Mode 0 counts a 13-bit value made of the high byte and bits [4:0] of the low byte. Bits [7:5] of the low byte are left unchanged. The count wraps from 0x1FFF to 0 and signals overflow.
- R7: Mode 1 counts the full 16-bit value {high, low}. It wraps from 0xFFFF to 0 and signals overflow.
- R8: Mode 2 increments only the low byte. When the low byte is 0xFF, the next step loads it from the high byte and signals overflow.
- R9: A channel overflow sets that channel's overflow flag. A tmr_ack pulse clears the flag, except when an overflow happens in the same cycle. A software write to the control register sets each flag to the written bit, and it overrides both the hardware set and the acknowledge.
- R10: With its type bit at 1, an interrupt flag is set on a falling edge of the synchronized interrupt input, and a xint_ack pulse clears it.
- R11: With its type bit at 0, an interrupt flag is set in every cycle the synchronized interrupt input is low. An acknowledge clears it only while the input is high.
- R12: Control register bits, from bit 7 down to bit 0: channel 1 overflow, channel 1 run, channel 0 overflow, channel 0 run, interrupt 1 flag, interrupt 1 type, interrupt 0 flag, interrupt 0 type. Count byte writes take priority over a count step in the same cycle.
- R13: After reset, all six registers read 0 and `cfg_err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| evt_in | input | 2 | Event lines, one per channel |
| gate_in | input | 2 | Gate levels, one per channel |
| xint_n | input | 2 | Active-low external interrupt inputs |
| tmr_ack | input | 2 | Overflow flag acknowledge, one per channel |
| xint_ack | input | 2 | Interrupt flag acknowledge, one per input |
| cfg_err | output | 1 | Illegal mode pairing programmed |

## Verification
The hardest cases to reach from the ports are the collisions at a wrap point. These include an overflow landing in the same cycle as a control write or an acknowledge, and a byte write landing in the same cycle as a 13-bit carry into the high byte. Directed phases preload the count bytes to a few steps below each mode's wrap point, and a long randomized phase then mixes writes, acknowledges, gate changes and event edges. Every cycle is compared against a behavioural model that tracks the synchronizer delay, so every collision that occurs is checked.

// File: rtl/dual_tc.sv
module dual_tc (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] bus_addr,
  input  logic       bus_we,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic [1:0] evt_in,
  input  logic [1:0] gate_in,
  input  logic [1:0] xint_n,
  input  logic [1:0] tmr_ack,
  input  logic [1:0] xint_ack,
  output logic       cfg_err
);

  logic [7:0] mode_q, ctrl_q;
  logic [7:0] lo_q [2];
  logic [7:0] hi_q [2];
  logic [7:0] lo_n [2];
  logic [7:0] hi_n [2];
  logic [1:0] ev_s1, ev_s2, ev_p, gt_s1, gt_s2, xi_s1, xi_s2, xi_p;
  logic [1:0] tick, ovf, ie_set;
  logic [7:0] hw_set, hw_clr;

  wire [1:0] ev_fall = ev_p & ~ev_s2;
  wire [1:0] xi_fall = xi_p & ~xi_s2;

  always_comb begin
    for (int c = 0; c < 2; c++) begin
      logic [3:0]  nb;
      logic [12:0] v13;
      logic [15:0] v16;
      nb  = mode_q[4*c +: 4];
      v13 = {hi_q[c], lo_q[c][4:0]} + 13'd1;
      v16 = {hi_q[c], lo_q[c]} + 16'd1;
      tick[c] = ctrl_q[4+2*c] && (!nb[3] || gt_s2[c]) && (!nb[2] || ev_fall[c]);
      lo_n[c] = lo_q[c];
      hi_n[c] = hi_q[c];
      ovf[c]  = 1'b0;
      if (tick[c]) begin
        case (nb[1:0])
          2'd0: begin
            hi_n[c]      = v13[12:5];
            lo_n[c][4:0] = v13[4:0];
            ovf[c]       = (v13 == 13'd0);
          end
          2'd1: begin
            {hi_n[c], lo_n[c]} = v16;
            ovf[c] = (v16 == 16'd0);
          end
          2'd2: begin
            if (&lo_q[c]) begin
              lo_n[c] = hi_q[c];
              ovf[c]  = 1'b1;
            end else begin
              lo_n[c] = lo_q[c] + 8'd1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign ie_set[0] = ctrl_q[0] ? xi_fall[0] : ~xi_s2[0];
  assign ie_set[1] = ctrl_q[2] ? xi_fall[1] : ~xi_s2[1];
  assign hw_set = {ovf[1], 1'b0, ovf[0], 1'b0, ie_set[1], 1'b0, ie_set[0], 1'b0};
  assign hw_clr = {tmr_ack[1], 1'b0, tmr_ack[0], 1'b0, xint_ack[1], 1'b0, xint_ack[0], 1'b0};

  assign cfg_err = (mode_q[1:0] == 2'd3) || (mode_q[5:4] == 2'd3) ||
                   (mode_q[1:0] == 2'd2 && mode_q[5:4] != 2'd2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      ctrl_q <= '0;
      ev_s1 <= '1; ev_s2 <= '1; ev_p <= '1;
      xi_s1 <= '1; xi_s2 <= '1; xi_p <= '1;
      gt_s1 <= '0; gt_s2 <= '0;
      for (int c = 0; c < 2; c++) begin
        lo_q[c] <= '0;
        hi_q[c] <= '0;
      end
    end else begin
      ev_s1 <= evt_in;  ev_s2 <= ev_s1; ev_p <= ev_s2;
      xi_s1 <= xint_n;  xi_s2 <= xi_s1; xi_p <= xi_s2;
      gt_s1 <= gate_in; gt_s2 <= gt_s1;
      if (bus_we && bus_addr == 3'd0) mode_q <= bus_wdata;
      if (bus_we && bus_addr == 3'd1) ctrl_q <= bus_wdata;
      else ctrl_q <= (ctrl_q | hw_set) & ~(hw_clr & ~hw_set);
      for (int c = 0; c < 2; c++) begin
        lo_q[c] <= (bus_we && bus_addr == 3'(2 + 2*c)) ? bus_wdata : lo_n[c];
        hi_q[c] <= (bus_we && bus_addr == 3'(3 + 2*c)) ? bus_wdata : hi_n[c];
      end
    end
  end

  always_comb begin
    case (bus_addr)
      3'd0: bus_rdata = mode_q;
      3'd1: bus_rdata = ctrl_q;
      3'd2: bus_rdata = lo_q[0];
      3'd3: bus_rdata = hi_q[0];
      3'd4: bus_rdata = lo_q[1];
      3'd5: bus_rdata = hi_q[1];
      default: bus_rdata = 8'h00;
    endcase
  end

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[4] && !bus_we) |=> (lo_q[0] == $past(lo_q[0]) && hi_q[0] == $past(hi_q[0])));

  // R2
  timer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[3:0] == 4'b0001 && ctrl_q[4] && !bus_we && lo_q[0] != 8'hFF)
      |=> (lo_q[0] == 8'($past(lo_q[0]) + 8'd1)));

  // R8
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[1:0] == 2'd2 && tick[0] && lo_q[0] == 8'hFF && !bus_we)
      |=> (lo_q[0] == $past(hi_q[0])));

  // R9
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf[0] && !bus_we) |=> ctrl_q[5]);

  // R9
  ack_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_ack[1] && !ovf[1] && !bus_we) |=> !ctrl_q[7]);

  // R10
  edge_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[0] && xi_fall[0] && !bus_we) |=> ctrl_q[1]);

endmodule

// File: tb/dual_tc_test.sv
`timescale 1ns/1ps
module dual_tc_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] bus_addr = 3'd0;
  logic bus_we = 1'b0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic [1:0] evt_in = 2'b11, gate_in = 2'b00, xint_n = 2'b11, tmr_ack = 2'b00, xint_ack = 2'b00;
  logic cfg_err;

  int total = 0, bad = 0;
  bit armed = 0, done = 0;
  string phase = "R13";
  int rd_ptr = 0;

  dual_tc uut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_in(evt_in), .gate_in(gate_in),
    .xint_n(xint_n), .tmr_ack(tmr_ack), .xint_ack(xint_ack), .cfg_err(cfg_err));

  always #2.5 clk = ~clk;

  int m_mode = 0, m_ctrl = 0;
  int m_lo[2] = '{0, 0};
  int m_hi[2] = '{0, 0};
  bit e1[2] = '{1, 1};
  bit e2[2] = '{1, 1};
  bit e3[2] = '{1, 1};
  bit g1[2] = '{0, 0};
  bit g2[2] = '{0, 0};
  bit x1[2] = '{1, 1};
  bit x2[2] = '{1, 1};
  bit x3[2] = '{1, 1};

  function automatic int model_read(int a);
    case (a)
      0: return m_mode;
      1: return m_ctrl;
      2: return m_lo[0];
      3: return m_hi[0];
      4: return m_lo[1];
      5: return m_hi[1];
      default: return 0;
    endcase
  endfunction

  function automatic bit model_err();
    int a, b;
    a = m_mode % 4;
    b = (m_mode / 16) % 4;
    return (a == 3) || (b == 3) || (a == 2 && b < 2);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_ctrl = 0;
      for (int c = 0; c < 2; c++) begin
        m_lo[c] = 0; m_hi[c] = 0;
        e1[c] = 1; e2[c] = 1; e3[c] = 1; x1[c] = 1; x2[c] = 1; x3[c] = 1; g1[c] = 0; g2[c] = 0;
      end
    end else begin
      int nctrl;
      int nlo[2];
      int nhi[2];
      bit of[2];
      for (int c = 0; c < 2; c++) begin
        int nib, v;
        bit go;
        nib = (m_mode >> (4*c)) & 15;
        go = ((m_ctrl >> (4 + 2*c)) & 1) == 1;
        if ((nib & 8) != 0 && !g2[c]) go = 0;
        if ((nib & 4) != 0 && !(e3[c] && !e2[c])) go = 0;
        nlo[c] = m_lo[c]; nhi[c] = m_hi[c]; of[c] = 0;
        if (go) begin
          case (nib & 3)
            0: begin
              v = m_hi[c] * 32 + (m_lo[c] & 31) + 1;
              if (v == 8192) begin v = 0; of[c] = 1; end
              nhi[c] = v / 32;
              nlo[c] = (m_lo[c] & 224) | (v & 31);
            end
            1: begin
              v = m_hi[c] * 256 + m_lo[c] + 1;
              if (v == 65536) begin v = 0; of[c] = 1; end
              nhi[c] = v / 256;
              nlo[c] = v % 256;
            end
            2: begin
              if (m_lo[c] == 255) begin nlo[c] = m_hi[c]; of[c] = 1; end
              else nlo[c] = m_lo[c] + 1;
            end
            default: ;
          endcase
        end
      end
      nctrl = m_ctrl;
      for (int c = 0; c < 2; c++) begin
        int tfb, ieb;
        bit xs;
        tfb = 5 + 2*c;
        ieb = 1 + 2*c;
        if (of[c]) nctrl |= (1 << tfb);
        else if (tmr_ack[c]) nctrl &= ~(1 << tfb);
        if (((m_ctrl >> (2*c)) & 1) == 1) xs = x3[c] && !x2[c];
        else xs = !x2[c];
        if (xs) nctrl |= (1 << ieb);
        else if (xint_ack[c]) nctrl &= ~(1 << ieb);
      end
      if (bus_we && bus_addr == 1) nctrl = bus_wdata;
      for (int c = 0; c < 2; c++) begin
        if (bus_we && bus_addr == 2 + 2*c) nlo[c] = bus_wdata;
        if (bus_we && bus_addr == 3 + 2*c) nhi[c] = bus_wdata;
        m_lo[c] = nlo[c]; m_hi[c] = nhi[c];
      end
      if (bus_we && bus_addr == 0) m_mode = bus_wdata;
      m_ctrl = nctrl;
      for (int c = 0; c < 2; c++) begin
        e3[c] = e2[c]; e2[c] = e1[c]; e1[c] = evt_in[c];
        x3[c] = x2[c]; x2[c] = x1[c]; x1[c] = xint_n[c];
        g2[c] = g1[c]; g1[c] = gate_in[c];
      end
    end
    armed = 1;
  end

  always @(negedge clk) begin
    if (armed && !done) begin
      int exp_r;
      exp_r = model_read(int'(bus_addr));
      total++;
      if (int'(bus_rdata) != exp_r) begin
        bad++;
        $display("FAIL %s addr=%0d actual=%02h expected=%02h", phase, bus_addr, bus_rdata, exp_r);
      end
      total++;
      if (cfg_err !== model_err()) begin
        bad++;
        $display("FAIL R1 cfg_err actual=%0b expected=%0b", cfg_err, model_err());
      end
    end
  end

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk); #1;
      bus_we = 0; bus_addr = 3'(rd_ptr); rd_ptr = (rd_ptr + 1) % 6;
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk); #1;
    bus_we = 1; bus_addr = 3'(a); bus_wdata = 8'(d);
  endtask

  task automatic ack(logic [1:0] t, logic [1:0] x);
    @(negedge clk); #1;
    bus_we = 0; tmr_ack = t; xint_ack = x;
    @(negedge clk); #1;
    tmr_ack = 0; xint_ack = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    phase = "R13";
    idle(4);
    rst_n = 1;
    idle(6);
    // R1 legal and illegal mode pairings, read back through R12 layout
    phase = "R1";
    wr(0, 8'h02); idle(2);
    wr(0, 8'h22); idle(2);
    wr(0, 8'h12); idle(2);
    wr(0, 8'h03); idle(2);
    wr(0, 8'h30); idle(2);
    wr(0, 8'h01); idle(2);
    // R2 timer mode 1 on both channels
    phase = "R2";
    wr(0, 8'h11); wr(1, 8'h50); idle(20);
    // R3 run bits cleared: counts hold
    phase = "R3";
    wr(1, 8'h00); idle(12);
    // R7 16-bit wrap and R9 flag, ack, clear-by-write
    phase = "R7";
    wr(2, 8'hFA); wr(3, 8'hFF); wr(4, 8'hFC); wr(5, 8'hFF); wr(1, 8'h50); idle(12);
    phase = "R9";
    ack(2'b01, 2'b00); idle(3);
    wr(1, 8'h50); idle(3);
    wr(2, 8'hFE); wr(3, 8'hFF); idle(1); wr(1, 8'h10); idle(4);
    wr(3, 8'hFF); wr(2, 8'hFF); ack(2'b01, 2'b00); idle(4);
    // R12 byte write beats a count step
    phase = "R12";
    wr(1, 8'h10); wr(2, 8'h40); wr(3, 8'h12); idle(4);
    // R6 13-bit mode, upper low-byte bits preserved
    phase = "R6";
    wr(1, 8'h00); wr(0, 8'h00); wr(2, 8'hFB); wr(3, 8'hFF); wr(1, 8'h10); idle(14);
    wr(2, 8'h1F); idle(1); wr(3, 8'h20); idle(6);
    // R8 reload mode
    phase = "R8";
    wr(1, 8'h00); wr(0, 8'h22); wr(3, 8'hF0); wr(2, 8'hFC); wr(5, 8'h80); wr(4, 8'hFE);
    wr(1, 8'h50); idle(40);
    // R4 gated timer
    phase = "R4";
    wr(1, 8'h00); wr(0, 8'h99); wr(2, 8'h00); wr(3, 8'h00); wr(1, 8'h50); idle(6);
    gate_in = 2'b01; idle(7);
    gate_in = 2'b10; idle(5);
    gate_in = 2'b11; idle(4);
    gate_in = 2'b00; idle(6);
    // R5 event counting
    phase = "R5";
    wr(1, 8'h00); wr(0, 8'h55); wr(1, 8'h50); idle(4);
    for (int k = 0; k < 10; k++) begin
      evt_in = 2'b00; idle(1 + k % 3);
      evt_in = 2'b11; idle(2 + k % 2);
      evt_in[k % 2] = 1'b0; idle(3);
      evt_in = 2'b11; idle(1);
    end
    // R10 edge-type interrupts
    phase = "R10";
    wr(1, 8'h05); idle(2);
    xint_n = 2'b10; idle(4); xint_n = 2'b11; idle(3);
    ack(2'b00, 2'b01); idle(2);
    xint_n = 2'b01; idle(5); ack(2'b00, 2'b10); xint_n = 2'b11; idle(4);
    // R11 level-type interrupts
    phase = "R11";
    wr(1, 8'h00); idle(2);
    xint_n = 2'b00; idle(4);
    ack(2'b00, 2'b11); idle(2);
    xint_n = 2'b11; idle(3);
    ack(2'b00, 2'b11); idle(3);
    // R9 mixed traffic around wrap points
    phase = "R9";
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk); #1;
      evt_in = 2'($urandom);
      gate_in = 2'($urandom);
      xint_n = 2'($urandom | $urandom);
      tmr_ack = (($urandom % 5) == 0) ? 2'($urandom) : 2'b00;
      xint_ack = (($urandom % 5) == 0) ? 2'($urandom) : 2'b00;
      bus_we = (($urandom % 7) == 0);
      bus_addr = 3'($urandom % 6);
      bus_wdata = (($urandom % 2) == 0) ? 8'hFF - 8'($urandom % 4) : 8'($urandom);
    end
    tmr_ack = 0; xint_ack = 0;
    idle(10);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule